// File: doc/BRIEF.md
# Global-History Branch Predictor

This block sits beside the fetch stage of a 32-bit in-order pipeline. It predicts whether the instruction at the fetch address is a taken branch, and where that branch goes. Each fetch address is presented with a lookup strobe. In the same cycle the block returns a taken bit, a next-fetch address, and the global history that was used for the lookup. The pipeline keeps that history with the branch as its checkpoint.

Three structures contribute to a prediction:
- A two-way set-associative target buffer says whether the address is a known branch, of which kind, and where it went last time.
- A table of 2-bit saturating counters gives the direction of conditional branches. The table is indexed by the global history XORed with fetch-address bits.
- A small return stack supplies the target of a subroutine return ahead of the target buffer.

When a branch completes, the execute stage reports it on the resolve port. The block then trains its tables, updates or repairs its history, and raises a same-cycle redirect with the corrected address when the branch was mispredicted.

Top module: `fetch_branch_predictor`

## Requirements
- R1: After reset every lookup misses: the taken bit is 0, the predicted target is the lookup address plus 4, and the reported history is 0.
- R2: A lookup whose address matches no valid target-buffer entry predicts not-taken with target address plus 4. The set is address bits [9:2] and the tag is bits [31:10].
- R3: A lookup that hits an entry of kind conditional (kind code 0) predicts taken, with the stored target, only when bit 1 of the 2-bit counter at index (history XOR address bits [13:2]) is set. Otherwise it predicts address plus 4. Counters start at 1 (weakly not-taken). A resolved conditional branch moves the counter at (checkpoint history XOR resolve address bits [13:2]) up on taken and down on not-taken, saturating at 3 and 0.
- R4: A lookup that hits an entry of kind jump (code 1) or call (code 2) predicts taken with the stored target.
- R5: A lookup that hits an entry of kind return (code 3) predicts taken. The target is the newest return-stack entry when the stack is not empty, and the stored target-buffer target when it is empty. A resolved call pushes its address plus 4. A resolved return pops, and does nothing when the stack is empty.
- R6: The return stack holds 8 entries. A ninth push discards the oldest entry, so after 9 or more calls only the 8 newest return addresses come back, newest first.
- R7: Only resolved conditional branches change the history. Without a mispredict flag the outcome is shifted into the current history. With the flag, the history becomes the resolve checkpoint shifted left by one with the outcome in bit 0. Other kinds leave the history unchanged.
- R8: In the cycle a resolve arrives with the mispredict flag set, the redirect output is high and carries the actual target when taken, or the resolve address plus 4 when not taken. Otherwise the redirect output is low with address 0.
- R9: A resolved taken branch writes its target and kind into the way that already holds its tag. If no way holds the tag, it writes the set's least-recently-written way, and that way becomes the set's most recent.
- R10: With the lookup strobe low, the taken bit and the target are 0. A lookup in the same cycle as a resolve sees the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_pc | input | 32 | Fetch address to predict |
| rs_valid | input | 1 | Resolve strobe |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | 32 | Actual target |
| rs_kind | input | 2 | 0 conditional, 1 jump, 2 call, 3 return |
| rs_mispredict | input | 1 | The earlier prediction for this branch was wrong |
| rs_ghist | input | 12 | History checkpointed at the branch's lookup |
| pr_taken | output | 1 | Predicted taken |
| pr_target | output | 32 | Predicted next fetch address |
| pr_ghist | output | 12 | Current global history, used for this lookup |
| redirect_valid | output | 1 | Fetch must restart this cycle |
| redirect_pc | output | 32 | Corrected fetch address |

## Verification
The bench replays a loop branch, a strictly alternating branch, nested and unbalanced call/return chains, and a ten-deep call chain. A table indexed without the history, or updated with the live history instead of the checkpoint, predicts the wrong direction on the alternating pattern. A stack that saturates instead of wrapping returns stale addresses after overflow. A stack that pops below empty corrupts the fallback to the stored target.

Three branches that map to one set show whether replacement evicts the way written least recently rather than a fixed way. A direct mispredicted resolve with an unrelated checkpoint exposes a history that is shifted rather than restored. A lookup in the same cycle as a resolve of the same address exposes any bypass of the pending write.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        BR_COND = 2'd0,
        BR_JUMP = 2'd1,
        BR_CALL = 2'd2,
        BR_RET  = 2'd3
    } br_kind_e;
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);
    localparam int ENTRIES = 1 << HIST_W;

    logic [1:0] ctr_q [ENTRIES];
    logic [1:0] ctr_d;

    // Saturating step of the counter being trained
    always_comb begin
        ctr_d = ctr_q[wr_idx];
        if (wr_taken && ctr_q[wr_idx] != 2'd3)
            ctr_d = ctr_q[wr_idx] + 2'd1;
        else if (!wr_taken && ctr_q[wr_idx] != 2'd0)
            ctr_d = ctr_q[wr_idx] - 2'd1;
    end

    assign rd_taken = ctr_q[rd_idx][1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'd1;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_d;
        end
    end

    assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] == 2'd3) |=> ctr_q[$past(wr_idx)] == 2'd3);
    assert_sat_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] == 2'd0) |=> ctr_q[$past(wr_idx)] == 2'd0);
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int SETS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:2] rd_pc,
    output logic        rd_hit,
    output logic [31:0] rd_target,
    output logic [1:0]  rd_kind,
    input  logic        wr_en,
    input  logic [31:2] wr_pc,
    input  logic [31:0] wr_target,
    input  logic [1:0]  wr_kind
);
    localparam int WAYS  = 2;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = 30 - SET_W;

    logic              vld_q [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [31:0]       tgt_q [SETS][WAYS];
    logic [1:0]        knd_q [SETS][WAYS];
    logic              lru_q [SETS];

    logic [SET_W-1:0]  rset, wset;
    logic [TAG_W-1:0]  rtag, wtag;
    logic [WAYS-1:0]   rhit, whit;
    logic              way_d;

    assign rset = rd_pc[SET_W+1:2];
    assign rtag = rd_pc[31:SET_W+2];
    assign wset = wr_pc[SET_W+1:2];
    assign wtag = wr_pc[31:SET_W+2];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign rhit[w] = vld_q[rset][w] && (tag_q[rset][w] == rtag);
        assign whit[w] = vld_q[wset][w] && (tag_q[wset][w] == wtag);
    end

    always_comb begin
        rd_hit    = |rhit;
        rd_target = rhit[1] ? tgt_q[rset][1] : tgt_q[rset][0];
        rd_kind   = rhit[1] ? knd_q[rset][1] : knd_q[rset][0];
        if (whit[0])      way_d = 1'b0;
        else if (whit[1]) way_d = 1'b1;
        else              way_d = lru_q[wset];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
            end
        end else if (wr_en) begin
            vld_q[wset][way_d] <= 1'b1;
            tag_q[wset][way_d] <= wtag;
            tgt_q[wset][way_d] <= wr_target;
            knd_q[wset][way_d] <= wr_kind;
            lru_q[wset]        <= ~way_d;
        end
    end

    always_comb begin
        if (rst_n && vld_q[wset][0] && vld_q[wset][1])
            assert_no_dup_R9: assert (tag_q[wset][0] != tag_q[wset][1]);
    end
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [31:0] push_val,
    input  logic        pop,
    output logic        top_ok,
    output logic [31:0] top_val
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt;
    } ras_t;

    ras_t        st_d, st_q;
    logic [31:0] stk_q [DEPTH];

    // Circular buffer: a push past full overwrites the oldest slot
    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.ptr = st_q.ptr + PW'(1);
            if (st_q.cnt != CW'(DEPTH)) st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop && st_q.cnt != '0) begin
            st_d.ptr = st_q.ptr - PW'(1);
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    assign top_ok  = st_q.cnt != '0;
    assign top_val = stk_q[st_q.ptr - PW'(1)];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
            if (push) stk_q[st_q.ptr] <= push_val;
        end
    end

    assert_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_full_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == CW'(DEPTH)) |=> st_q.cnt == CW'(DEPTH));
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !top_ok) |=> !top_ok);
endmodule

// File: rtl/fetch_branch_predictor.sv
module fetch_branch_predictor
    import bp_pkg::*;
#(
    parameter int BTB_SETS  = 256,
    parameter int HIST_W    = 12,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_pc,
    input  logic              rs_valid,
    input  logic [31:0]       rs_pc,
    input  logic              rs_taken,
    input  logic [31:0]       rs_target,
    input  logic [1:0]        rs_kind,
    input  logic              rs_mispredict,
    input  logic [HIST_W-1:0] rs_ghist,
    output logic              pr_taken,
    output logic [31:0]       pr_target,
    output logic [HIST_W-1:0] pr_ghist,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc
);
    typedef struct packed {
        logic [HIST_W-1:0] ghr;
    } hist_t;

    hist_t             st_d, st_q;
    logic              rs_cond;
    logic [HIST_W-1:0] lk_idx, rs_idx;
    logic              dir_taken, btb_hit, ras_ok;
    logic [31:0]       btb_tgt, ras_top;
    logic [1:0]        btb_kind;

    assign rs_cond = rs_valid && (br_kind_e'(rs_kind) == BR_COND);
    assign lk_idx  = st_q.ghr ^ lk_pc[HIST_W+1:2];
    assign rs_idx  = rs_ghist ^ rs_pc[HIST_W+1:2];

    bp_dir_table #(.HIST_W(HIST_W)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_taken(dir_taken),
        .wr_en(rs_cond), .wr_idx(rs_idx), .wr_taken(rs_taken)
    );

    bp_target_buf #(.SETS(BTB_SETS)) u_btb (
        .clk(clk), .rst_n(rst_n),
        .rd_pc(lk_pc[31:2]), .rd_hit(btb_hit), .rd_target(btb_tgt), .rd_kind(btb_kind),
        .wr_en(rs_valid && rs_taken), .wr_pc(rs_pc[31:2]),
        .wr_target(rs_target), .wr_kind(rs_kind)
    );

    bp_ret_stack #(.DEPTH(RAS_DEPTH)) u_ras (
        .clk(clk), .rst_n(rst_n),
        .push(rs_valid && br_kind_e'(rs_kind) == BR_CALL), .push_val(rs_pc + 32'd4),
        .pop(rs_valid && br_kind_e'(rs_kind) == BR_RET),
        .top_ok(ras_ok), .top_val(ras_top)
    );

    // History: shift on a correct conditional, rebuild from checkpoint on a miss
    always_comb begin
        st_d = st_q;
        if (rs_cond) begin
            if (rs_mispredict) st_d.ghr = {rs_ghist[HIST_W-2:0], rs_taken};
            else               st_d.ghr = {st_q.ghr[HIST_W-2:0], rs_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Prediction from pre-update state
    always_comb begin
        pr_taken  = 1'b0;
        pr_target = '0;
        if (lk_valid) begin
            pr_target = lk_pc + 32'd4;
            if (btb_hit) begin
                case (br_kind_e'(btb_kind))
                    BR_COND: if (dir_taken) begin
                        pr_taken  = 1'b1;
                        pr_target = btb_tgt;
                    end
                    BR_RET: begin
                        pr_taken  = 1'b1;
                        pr_target = ras_ok ? ras_top : btb_tgt;
                    end
                    default: begin
                        pr_taken  = 1'b1;
                        pr_target = btb_tgt;
                    end
                endcase
            end
        end
    end

    assign pr_ghist       = st_q.ghr;
    assign redirect_valid = rs_valid && rs_mispredict;
    assign redirect_pc    = redirect_valid ? (rs_taken ? rs_target : rs_pc + 32'd4) : 32'd0;

    always_comb begin
        if (rst_n && lk_valid && !btb_hit)
            assert_miss_R2: assert (!pr_taken && pr_target == lk_pc + 32'd4);
        if (rst_n && !lk_valid)
            assert_idle_R10: assert (!pr_taken && pr_target == 32'd0);
    end

    assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_cond && rs_mispredict) |=>
            pr_ghist == {$past(rs_ghist[HIST_W-2:0]), $past(rs_taken)});
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_cond |=> $stable(pr_ghist));
endmodule

// File: tb/fetch_branch_predictor_test.sv
module fetch_branch_predictor_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, rs_valid, rs_taken, rs_mispredict;
    logic [31:0] lk_pc, rs_pc, rs_target;
    logic [1:0]  rs_kind;
    logic [11:0] rs_ghist;
    logic        pr_taken, redirect_valid;
    logic [31:0] pr_target, redirect_pc;
    logic [11:0] pr_ghist;

    always #2 clk = ~clk;

    fetch_branch_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_kind(rs_kind), .rs_mispredict(rs_mispredict), .rs_ghist(rs_ghist),
        .pr_taken(pr_taken), .pr_target(pr_target), .pr_ghist(pr_ghist),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural reference state
    int          m_pht [4096];
    bit          m_v   [256][2];
    int          m_tag [256][2];
    logic [31:0] m_tg  [256][2];
    int          m_k   [256][2];
    int          m_lru [256];
    logic [31:0] m_ras [$];
    int          m_ghr;

    bit          p_t;
    logic [31:0] p_tg;
    int          p_gh;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit lkv, input logic [31:0] lpc, input bit rsv, input logic [31:0] rpc,
                        input bit rt, input logic [31:0] rtg, input int rk, input bit rm,
                        input int rck, input string tag);
        int s, hit, w, ix;
        bit et;
        logic [31:0] etg;
        @(negedge clk);
        lk_valid = lkv; lk_pc = lpc;
        rs_valid = rsv; rs_pc = rpc; rs_taken = rt; rs_target = rtg;
        rs_kind = 2'(rk); rs_mispredict = rm; rs_ghist = 12'(rck);
        #1;
        et = 1'b0; etg = 32'd0;
        if (lkv) begin
            s = int'(lpc[9:2]); hit = -1; etg = lpc + 32'd4;
            for (int k = 0; k < 2; k++)
                if (m_v[s][k] && m_tag[s][k] == int'(lpc[31:10])) hit = k;
            if (hit >= 0) begin
                case (m_k[s][hit])
                    0: if (m_pht[(m_ghr ^ int'(lpc[13:2])) & 4095] >= 2) begin
                           et = 1'b1; etg = m_tg[s][hit];
                       end
                    3: begin
                           et = 1'b1;
                           etg = (m_ras.size() > 0) ? m_ras[$] : m_tg[s][hit];
                       end
                    default: begin et = 1'b1; etg = m_tg[s][hit]; end
                endcase
            end
        end
        chk(lkv ? tag : "R10", "pr_taken", 32'(pr_taken), 32'(et));
        chk(lkv ? tag : "R10", "pr_target", pr_target, etg);
        chk("R7", "pr_ghist", 32'(pr_ghist), 32'(m_ghr));
        chk("R8", "redirect_valid", 32'(redirect_valid), 32'(rsv && rm));
        chk("R8", "redirect_pc", redirect_pc, (rsv && rm) ? (rt ? rtg : rpc + 32'd4) : 32'd0);
        p_t = et; p_tg = etg; p_gh = m_ghr;
        if (rsv) begin
            s = int'(rpc[9:2]);
            if (rt) begin
                hit = -1;
                for (int k = 0; k < 2; k++)
                    if (m_v[s][k] && m_tag[s][k] == int'(rpc[31:10])) hit = k;
                w = (hit >= 0) ? hit : m_lru[s];
                m_v[s][w] = 1'b1; m_tag[s][w] = int'(rpc[31:10]);
                m_tg[s][w] = rtg; m_k[s][w] = rk; m_lru[s] = 1 - w;
            end
            if (rk == 0) begin
                ix = (rck ^ int'(rpc[13:2])) & 4095;
                if (rt && m_pht[ix] < 3) m_pht[ix]++;
                else if (!rt && m_pht[ix] > 0) m_pht[ix]--;
                m_ghr = rm ? (((rck << 1) | int'(rt)) & 4095) : (((m_ghr << 1) | int'(rt)) & 4095);
            end
            if (rk == 2) begin
                m_ras.push_back(rpc + 32'd4);
                if (m_ras.size() > 8) void'(m_ras.pop_front());
            end
            if (rk == 3 && m_ras.size() > 0) void'(m_ras.pop_back());
        end
    endtask

    task automatic look(input logic [31:0] pc, input string tag);
        step(1'b1, pc, 1'b0, 32'd0, 1'b0, 32'd0, 0, 1'b0, 0, tag);
    endtask

    // One branch as a pipeline sees it: predict, then resolve with checkpoint
    task automatic branch(input logic [31:0] pc, input bit t, input logic [31:0] tgt, input int k, input string tag);
        bit mis;
        look(pc, tag);
        mis = (p_t != t) || (t && p_tg != tgt);
        step(1'b0, 32'd0, 1'b1, pc, t, tgt, k, mis, p_gh, tag);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) m_pht[i] = 1;
        for (int s = 0; s < 256; s++) begin
            m_lru[s] = 0; m_v[s][0] = 1'b0; m_v[s][1] = 1'b0;
        end
        m_ghr = 0;
        rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0; rs_valid = 1'b0; rs_pc = '0;
        rs_taken = 1'b0; rs_target = '0; rs_kind = '0; rs_mispredict = 1'b0; rs_ghist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        look(32'h0000_0100, "R1");
        look(32'h0000_6000, "R1");
        // R2: miss on a not-taken conditional
        branch(32'h0000_0200, 1'b0, 32'h0000_0300, 0, "R2");
        look(32'h0000_0200, "R2");
        // R3: loop pattern (seven taken, one exit)
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 8; i++) branch(32'h0000_2040, i < 7, 32'h0000_2000, 0, "R3");
        // R3: alternating pattern
        for (int i = 0; i < 16; i++) branch(32'h0000_3080, (i % 2) == 1, 32'h0000_3000, 0, "R3");
        // R4: unconditional jump
        for (int i = 0; i < 3; i++) branch(32'h0000_4000, 1'b1, 32'h0000_5000, 1, "R4");
        // R5: call/return pairs and nesting
        for (int i = 0; i < 3; i++) begin
            branch(32'h0000_6000, 1'b1, 32'h0000_7000, 2, "R5");
            branch(32'h0000_7010, 1'b1, 32'h0000_6004, 3, "R5");
        end
        for (int i = 0; i < 2; i++) begin
            branch(32'h0000_6100, 1'b1, 32'h0000_7100, 2, "R5");
            branch(32'h0000_7104, 1'b1, 32'h0000_7200, 2, "R5");
            branch(32'h0000_7210, 1'b1, 32'h0000_7108, 3, "R5");
            branch(32'h0000_7110, 1'b1, 32'h0000_6104, 3, "R5");
        end
        // R5: empty stack falls back to stored target
        look(32'h0000_7010, "R5");
        // R6: ten calls deep, then unwind
        for (int i = 0; i < 10; i++) branch(32'h0000_8000 + 32'(16 * i), 1'b1, 32'h0000_9000, 2, "R6");
        for (int i = 9; i >= 0; i--) branch(32'h0000_9100, 1'b1, 32'h0000_8004 + 32'(16 * i), 3, "R6");
        look(32'h0000_9100, "R6");
        // R9: three branches in one set
        branch(32'h0000_1008, 1'b1, 32'h0000_B000, 1, "R9");
        branch(32'h0000_1408, 1'b1, 32'h0000_B400, 1, "R9");
        branch(32'h0000_1008, 1'b1, 32'h0000_B000, 1, "R9");
        branch(32'h0000_1808, 1'b1, 32'h0000_B800, 1, "R9");
        look(32'h0000_1008, "R9");
        look(32'h0000_1408, "R9");
        look(32'h0000_1808, "R9");
        // R7: restore from checkpoint, then a non-conditional leaves history alone
        step(1'b0, 32'd0, 1'b1, 32'h0000_2100, 1'b1, 32'h0000_2200, 0, 1'b1, 'hABC, "R7");
        look(32'h0000_2300, "R7");
        step(1'b0, 32'd0, 1'b1, 32'h0000_4000, 1'b1, 32'h0000_5000, 1, 1'b0, 0, "R7");
        look(32'h0000_2300, "R7");
        // R8: not-taken mispredict redirects to fall-through
        step(1'b0, 32'd0, 1'b1, 32'h0000_2100, 1'b0, 32'h0000_2200, 0, 1'b1, 5, "R8");
        // R10: lookup concurrent with a retargeting resolve of the same address
        step(1'b1, 32'h0000_1808, 1'b1, 32'h0000_1808, 1'b1, 32'h0000_C000, 1, 1'b1, 0, "R10");
        look(32'h0000_1808, "R10");
        step(1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 32'd0, 0, 1'b0, 0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule